// File: doc/BRIEF.md
# GPIO Interrupt Trigger Detector

This block watches a bank of sixteen general-purpose input pins and turns activity on the upper ten of them (pins 6 to 15) into per-pin interrupt requests. Each pin has a 3-bit trigger-style field that selects one of five conditions: high level, low level, rising edge, falling edge, or any edge. The fields are packed eight to a register, so two style registers cover all sixteen pins.

The pins are asynchronous to the block clock. Each one passes through a two-flop synchroniser, and edges are found by comparing the synchronised sample with the sample from one clock earlier. A matching condition sets that pin's pending bit. The pending bit drives the pin's interrupt output directly, and software clears it by writing a one to its position in the pending register.

A level-style pending bit is re-asserted on every cycle that its condition holds, so a clear has no effect until the input has gone inactive. When an edge event and a clear of the same bit fall in the same cycle, the bit stays set. The asynchronous active-low reset is released synchronously inside the block.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every style field holds code 7 (detection off), so both style registers read 0x00FFFFFF, the pending register reads 0, and every interrupt output is low.
- R2: Pins 0 to 5 never set a pending bit under any style code or input activity. Their style fields are still stored and read back.
- R3: With style code 2 (rising), a low-to-high change on a pin sets its pending bit at the third rising clock edge after the change. A high-to-low change does not set it.
- R4: With style code 3 (falling), a high-to-low change sets the pending bit. A low-to-high change does not.
- R5: With style code 4 (any edge), a change in either direction sets the pending bit.
- R6: With style code 0 (high level), the pending bit is set while the synchronised input is high. A one-write to clear it has no effect while the input stays high. The bit stays set after the input falls, and a clear issued after the fall removes it.
- R7: With style code 1 (low level), the pending bit is set while the synchronised input is low, and it cannot be cleared while the input stays low.
- R8: A write to address 2 clears every pending bit whose data bit is 1 and leaves every bit whose data bit is 0 untouched, provided no detection event for that pin occurs in the same cycle.
- R9: If a detection event and a clearing write for the same pin occur in the same cycle, the pending bit is set after that cycle.
- R10: Style codes 5, 6 and 7 disable detection on the pin. Its pending bit never becomes set.
- R11: interrupt output n equals pending bit n. A read at address 2 returns the pending bits in data bits 15:0 and zeros above them.
- R12: Pin n's style field lives in the register at address n/8, in bits [3*(n mod 8)+2 : 3*(n mod 8)]. Writes keep data bits 23:0. Bits 31:24 read as 0, and address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 16 | Raw asynchronous input pins |
| reg_we | input | 1 | Register write strobe, one write per cycle high |
| reg_addr | input | 2 | Register address: 0 low-pin styles, 1 high-pin styles, 2 pending |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_out | output | 16 | Per-pin interrupt request, one bit per pin |

## Verification
The properties assume that every pin is held steady long enough to pass through the synchroniser. They also assume that register writes are single-cycle strobes, with address and data stable while the strobe is high. The stimulus changes pins and write signals only on falling clock edges and leaves at least four cycles between a pin change and the check that follows it. Every sequence starts by writing detection-off codes to both style registers, so leftover levels from the previous sequence cannot raise unexpected pending bits. The one test that deliberately lines a clear up with an edge event counts synchroniser stages to place the write in the cycle where the event occurs.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int STYLE_W       = 3;
  localparam int PINS_PER_BANK = 8;

  typedef enum logic [STYLE_W-1:0] {
    TRIG_LVL_HIGH = 3'd0,
    TRIG_LVL_LOW  = 3'd1,
    TRIG_RISE     = 3'd2,
    TRIG_FALL     = 3'd3,
    TRIG_BOTH     = 3'd4,
    TRIG_OFF      = 3'd7
  } trig_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] samp_q,
  output logic [WIDTH-1:0] prev_q
);
  logic [WIDTH-1:0] meta_q;

  // two flops for metastability, one more holding the previous sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      samp_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_in;
      samp_q <= meta_q;
      prev_q <= samp_q;
    end
  end
endmodule

// File: rtl/gpio_style_regs.sv
module gpio_style_regs #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 24,
  parameter int ADDR_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BANK_W-1:0]           wdata,
  output logic [NUM_BANKS*BANK_W-1:0] style_flat
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              wr_en;
    logic [BANK_W-1:0] bank_d;
    logic [BANK_W-1:0] bank_q;

    always_comb begin
      wr_en  = we && (addr == ADDR_W'(b));
      bank_d = wdata;
    end

    // reset to all ones: every field at the detection-off code
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bank_q <= '1;
      else if (wr_en) bank_q <= bank_d;
    end

    assign style_flat[b*BANK_W +: BANK_W] = bank_q;
  end
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STYLE_W-1:0] style,
  input  logic               samp,
  input  logic               prev,
  input  logic               clr,
  output logic               pend_q
);
  logic hit;
  logic pend_d;

  always_comb begin
    case (style)
      TRIG_LVL_HIGH: hit = samp;
      TRIG_LVL_LOW:  hit = ~samp;
      TRIG_RISE:     hit = samp & ~prev;
      TRIG_FALL:     hit = ~samp & prev;
      TRIG_BOTH:     hit = samp ^ prev;
      default:       hit = 1'b0;
    endcase
    // a new event outranks a same-cycle clear
    pend_d = hit | (pend_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS      = 16,
  parameter int FIRST_IRQ_PIN = 6,
  parameter int ADDR_W        = 2,
  parameter int DATA_W        = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [NUM_PINS-1:0] irq_out
);
  localparam int NUM_BANKS = (NUM_PINS + PINS_PER_BANK - 1) / PINS_PER_BANK;
  localparam int BANK_W    = PINS_PER_BANK * STYLE_W;
  localparam int ADDR_PEND = NUM_BANKS;

  logic                        rst_sync_n;
  logic [NUM_PINS-1:0]         samp_q;
  logic [NUM_PINS-1:0]         prev_q;
  logic [NUM_BANKS*BANK_W-1:0] style_flat;
  logic [NUM_PINS-1:0]         pend_q;
  logic                        clr_wr;
  logic [NUM_PINS-1:0]         clr_vec;
  logic                        sig_unused;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .raw_in (pin_in),
    .samp_q (samp_q),
    .prev_q (prev_q)
  );

  gpio_style_regs #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W)
  ) u_style (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata[BANK_W-1:0]),
    .style_flat (style_flat)
  );

  assign clr_wr  = reg_we && (reg_addr == ADDR_W'(ADDR_PEND));
  assign clr_vec = {NUM_PINS{clr_wr}} & reg_wdata[NUM_PINS-1:0];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p >= FIRST_IRQ_PIN) begin : g_det
      gpio_pin_detect u_det (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .style  (style_flat[p*STYLE_W +: STYLE_W]),
        .samp   (samp_q[p]),
        .prev   (prev_q[p]),
        .clr    (clr_vec[p]),
        .pend_q (pend_q[p])
      );
    end else begin : g_none
      assign pend_q[p] = 1'b0;
    end
  end

  assign irq_out = pend_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_PEND)) begin
      reg_rdata[NUM_PINS-1:0] = pend_q;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (reg_addr == ADDR_W'(b)) reg_rdata[BANK_W-1:0] = style_flat[b*BANK_W +: BANK_W];
      end
    end
  end

  assign sig_unused = ^{reg_wdata[DATA_W-1:BANK_W], clr_vec[FIRST_IRQ_PIN-1:0],
                        samp_q[FIRST_IRQ_PIN-1:0], prev_q[FIRST_IRQ_PIN-1:0]};
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS      = 16,
  parameter int FIRST_IRQ_PIN = 6,
  parameter int ADDR_W        = 2,
  parameter int DATA_W        = 32,
  parameter int STYLE_BITS    = 48,
  parameter int ADDR_PEND     = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [DATA_W-1:0]     reg_wdata,
  input logic [DATA_W-1:0]     reg_rdata,
  input logic [NUM_PINS-1:0]   irq_out,
  input logic [STYLE_BITS-1:0] style_flat,
  input logic [NUM_PINS-1:0]   samp,
  input logic [NUM_PINS-1:0]   prev
);
  AST_PEND_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(ADDR_PEND)) |-> (reg_rdata[NUM_PINS-1:0] == irq_out)); // R11

  for (genvar i = FIRST_IRQ_PIN; i < NUM_PINS; i++) begin : g_chk
    logic [STYLE_W-1:0] sty;
    logic               clr;
    assign sty = style_flat[i*STYLE_W +: STYLE_W];
    assign clr = reg_we && (reg_addr == ADDR_W'(ADDR_PEND)) && reg_wdata[i];

    AST_LEVEL_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sty == TRIG_LVL_HIGH && samp[i]) |=> irq_out[i]); // R6
    AST_LEVEL_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sty == TRIG_LVL_LOW && !samp[i]) |=> irq_out[i]); // R7
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (sty == TRIG_RISE && samp[i] && !prev[i]) |=> irq_out[i]); // R3
    AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (sty == TRIG_FALL && !samp[i] && prev[i]) |=> irq_out[i]); // R4
    AST_BOTH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (sty == TRIG_BOTH && (samp[i] != prev[i])) |=> irq_out[i]); // R5
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && sty == TRIG_BOTH && (samp[i] != prev[i])) |=> irq_out[i]); // R9
    AST_CLEAR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && sty >= TRIG_RISE && sty <= TRIG_BOTH && samp[i] == prev[i]) |=> !irq_out[i]); // R8
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (sty > TRIG_BOTH && (!irq_out[i] || clr)) |=> !irq_out[i]); // R10
  end
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(
  .NUM_PINS      (NUM_PINS),
  .FIRST_IRQ_PIN (FIRST_IRQ_PIN),
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .STYLE_BITS    (NUM_BANKS*BANK_W),
  .ADDR_PEND     (ADDR_PEND)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .irq_out    (irq_out),
  .style_flat (style_flat),
  .samp       (samp_q),
  .prev       (prev_q)
);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // {pin[3:0], style[2:0], v0, v1, exp_pre, exp_post}
  localparam logic [10:0] VECS [NV] = '{
    {4'd6,  3'd2, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 rise
    {4'd7,  3'd2, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 fall ignored
    {4'd8,  3'd3, 1'b1, 1'b0, 1'b0, 1'b1},  // R4
    {4'd9,  3'd3, 1'b0, 1'b1, 1'b0, 1'b0},  // R4
    {4'd10, 3'd4, 1'b0, 1'b1, 1'b0, 1'b1},  // R5
    {4'd11, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1},  // R5
    {4'd12, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1},  // R6
    {4'd13, 3'd1, 1'b0, 1'b1, 1'b1, 1'b1},  // R7
    {4'd14, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},  // R6 inactive
    {4'd15, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0},  // R10
    {4'd6,  3'd7, 1'b1, 1'b0, 1'b0, 1'b0},  // R10
    {4'd3,  3'd2, 1'b0, 1'b1, 1'b0, 1'b0},  // R2
    {4'd0,  3'd4, 1'b0, 1'b1, 1'b0, 1'b0},  // R2
    {4'd15, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1}   // R3 top pin
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin_in = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  gpio_irq_detect u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic string req_of(input int pin, input int sty);
    if (pin < 6) return "R2";
    case (sty)
      0: return "R6";
      1: return "R7";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] style_word(input int pin, input int sty);
    int f = (pin % 8) * 3;
    return (32'h00FF_FFFF & ~(32'd7 << f)) | (32'(sty) << f);
  endfunction

  task automatic disable_all();
    write_reg(2'd0, 32'h00FF_FFFF);
    write_reg(2'd1, 32'h00FF_FFFF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(4);

    // R1 reset state
    check_eq("R1", "irq after reset", 32'(irq_out), 32'h0);
    read_reg(2'd0, rd); check_eq("R1", "style lo reset", rd, 32'h00FF_FFFF);
    read_reg(2'd1, rd); check_eq("R1", "style hi reset", rd, 32'h00FF_FFFF);
    read_reg(2'd2, rd); check_eq("R1", "pending reset", rd, 32'h0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      int pin, sty;
      logic v0, v1, epre, epost;
      logic [15:0] one;
      pin = int'(VECS[v][10:7]);
      sty = int'(VECS[v][6:4]);
      v0 = VECS[v][3]; v1 = VECS[v][2]; epre = VECS[v][1]; epost = VECS[v][0];
      one = 16'd1 << pin;
      disable_all();
      pin_in = v0 ? one : 16'h0;
      wait_cycles(4);
      write_reg(2'd2, 32'h0000_FFFF);
      write_reg(2'(pin / 8), style_word(pin, sty));
      wait_cycles(4);
      check_eq(req_of(pin, sty), $sformatf("vec %0d before change", v), 32'(irq_out), epre ? 32'(one) : 32'h0);
      write_reg(2'd2, 32'(one));
      pin_in = v1 ? one : 16'h0;
      wait_cycles(4);
      check_eq(req_of(pin, sty), $sformatf("vec %0d after change", v), 32'(irq_out), epost ? 32'(one) : 32'h0);
      read_reg(2'd2, rd);
      check_eq("R11", $sformatf("vec %0d pending read", v), rd, epost ? 32'(one) : 32'h0);
    end

    // R12 field placement and readback width
    disable_all();
    write_reg(2'd1, 32'hABCD_EF12);
    read_reg(2'd1, rd); check_eq("R12", "style hi keeps 24 bits", rd, 32'h00CD_EF12);
    read_reg(2'd0, rd); check_eq("R12", "style lo untouched", rd, 32'h00FF_FFFF);
    read_reg(2'd3, rd); check_eq("R12", "unused address", rd, 32'h0);
    disable_all();

    // R8 zero bits leave pending alone, one bits clear it
    pin_in = 16'h0;
    wait_cycles(4);
    write_reg(2'd2, 32'h0000_FFFF);
    write_reg(2'd0, style_word(6, 2));
    pin_in = 16'h0040;
    wait_cycles(4);
    write_reg(2'd2, 32'h0000_FFBF);
    wait_cycles(1);
    check_eq("R8", "zero bit keeps pending", 32'(irq_out), 32'h0040);
    write_reg(2'd2, 32'h0000_0040);
    wait_cycles(1);
    check_eq("R8", "one bit clears pending", 32'(irq_out), 32'h0);

    // R9 event in the same cycle as its clear
    pin_in = 16'h0;
    wait_cycles(4);
    pin_in = 16'h0040;
    wait_cycles(4);
    pin_in = 16'h0;
    wait_cycles(4);
    check_eq("R9", "pending before collision", 32'(irq_out), 32'h0040);
    @(negedge clk); pin_in = 16'h0040;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0000_0040;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
    check_eq("R9", "event beats clear", 32'(irq_out), 32'h0040);
    wait_cycles(2);
    write_reg(2'd2, 32'h0000_0040);
    wait_cycles(1);
    check_eq("R8", "clear without event", 32'(irq_out), 32'h0);

    // R6 sticky level: clear blocked while high, works after fall
    disable_all();
    pin_in = 16'h1000;
    wait_cycles(4);
    write_reg(2'd2, 32'h0000_FFFF);
    write_reg(2'd1, style_word(12, 0));
    wait_cycles(2);
    write_reg(2'd2, 32'h0000_1000);
    wait_cycles(1);
    check_eq("R6", "clear ignored while high", 32'(irq_out), 32'h1000);
    pin_in = 16'h0;
    wait_cycles(4);
    check_eq("R6", "held after fall", 32'(irq_out), 32'h1000);
    write_reg(2'd2, 32'h0000_1000);
    wait_cycles(1);
    check_eq("R6", "clear after fall", 32'(irq_out), 32'h0);

    // R7 low level cannot be cleared while low
    disable_all();
    write_reg(2'd2, 32'h0000_FFFF);
    write_reg(2'd1, style_word(13, 1));
    wait_cycles(2);
    write_reg(2'd2, 32'h0000_2000);
    wait_cycles(1);
    check_eq("R7", "clear ignored while low", 32'(irq_out), 32'h2000);
    disable_all();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule